// File: doc/BRIEF.md
# Constant-Pattern Modular Exponentiation Sequencer

This block drives an external modular multiplier through a left-to-right binary exponentiation, so that the sequence of commands it issues is identical for every secret exponent. After a start request it loads a message and an exponent of `EXP_W` bits. It sets the accumulator register to one and then walks the exponent from its top bit down to bit 0. For every bit it first requests a squaring of the accumulator and then a multiplication of the accumulator by the message.

The multiplication is never skipped. When the current key bit is one, the product replaces the accumulator. When the bit is zero, the product goes to a dummy register that nothing reads back into the computation. The multiplier is reached through a one-command-at-a-time start/done port. The sequencer presents the operands, an operation code and a destination select, and writes the returned value into the selected register. The modulus lives entirely in the multiplier, so the sequencer is independent of the arithmetic.

When the last bit is done, the accumulator is copied to the result output and announced with a one-cycle valid pulse.

Top module: `modexp_seq`

## Requirements
- R1: After reset, `busy`, `result_valid` and `mul_start` are all 0.
- R2: A `start` seen while idle is accepted at that clock edge. `busy` is 1 from the next cycle. The first command squares an accumulator that has been set to 1, so `mul_a` = `mul_b` = 1.
- R3: Commands strictly alternate square, multiply, square, multiply, and so on, beginning with a square. One square/multiply pair is issued per exponent bit, taken from bit EXP_W-1 down to bit 0.
- R4: A square command carries `mul_op` = 0 and `mul_dst` = 0, with `mul_a` and `mul_b` both equal to the current accumulator value.
- R5: A multiply command carries `mul_op` = 1, `mul_a` = accumulator and `mul_b` = message. `mul_dst` = 0 (accumulator) when the key bit is 1 and `mul_dst` = 1 (dummy) when the key bit is 0. A write to the dummy leaves the accumulator unchanged.
- R6: Every run issues exactly 2·EXP_W commands, whatever the exponent value.
- R7: `mul_start` is a one-cycle pulse. No new command is issued until `mul_done` has returned the previous result.
- R8: `result` equals message^exponent mod N, where N is the multiplier's modulus. `result_valid` is a single-cycle pulse, and `result` holds its value until the next run finishes.
- R9: `start` is ignored while `busy` is 1. The message and exponent of the running job are neither reloaded nor disturbed.
- R10: `busy` stays 1 from the cycle after acceptance until `result_valid` rises, and is 0 in the cycle `result_valid` is 1.
- R11: An all-zero exponent still issues 2·EXP_W commands and returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new exponentiation (used only while idle) |
| exp_in | input | EXP_W | Secret exponent, sampled on an accepted start |
| msg_in | input | DATA_W | Message, sampled on an accepted start |
| busy | output | 1 | A run is in progress |
| result_valid | output | 1 | One-cycle pulse: `result` is new |
| result | output | DATA_W | Final accumulator value |
| mul_start | output | 1 | One-cycle command strobe to the multiplier |
| mul_op | output | 1 | 0 = square, 1 = multiply by message |
| mul_dst | output | 1 | Destination: 0 = accumulator, 1 = dummy |
| mul_a | output | DATA_W | First operand (accumulator) |
| mul_b | output | DATA_W | Second operand (accumulator or message) |
| mul_done | input | 1 | One-cycle pulse: `mul_res` is valid |
| mul_res | input | DATA_W | Product returned by the multiplier |

## Verification
The hardest situation to reach from the ports is a second `start` that arrives in the middle of a run while the multiplier is still holding a command. The bench raises `start` with a different exponent and message a few cycles into a job and keeps the multiplier latency above zero, so that the request lands during a wait state. The only visible proof that it was ignored is the final result and the untouched command stream. A port-side monitor therefore recomputes the expected accumulator, key bit and destination for every command, and checks them against the first job's operands.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic {
    OP_SQR = 1'b0,
    OP_MUL = 1'b1
  } mm_op_e;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_SQR_GO   = 3'd1,
    S_SQR_WAIT = 3'd2,
    S_MUL_GO   = 3'd3,
    S_MUL_WAIT = 3'd4,
    S_FIN      = 3'd5
  } seq_state_e;

  // Destination of the per-bit multiply: accumulator (0) for a one bit,
  // dummy (1) for a zero bit.
  function automatic logic mul_target(input logic key_bit);
    return ~key_bit;
  endfunction

  // Commands per run for a t-bit exponent.
  function automatic int cmd_budget(input int t);
    return 2 * t;
  endfunction

endpackage

// File: rtl/mx_bit_scanner.sv
module mx_bit_scanner #(
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [EXP_W-1:0] exp_in,
  output logic             cur_bit,
  output logic             last_bit
);
  localparam int CW = $clog2(EXP_W + 1);

  logic [EXP_W-1:0] key_q;
  logic [CW-1:0]    left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      key_q  <= exp_in;
      left_q <= CW'(EXP_W);
    end else if (shift) begin
      key_q  <= {key_q[EXP_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign cur_bit  = key_q[EXP_W-1];
  assign last_bit = (left_q == CW'(1));

  // R3: the bit count never wraps through zero while scanning
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> left_q != '0);

endmodule

// File: rtl/mx_regfile.sv
module mx_regfile #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [DATA_W-1:0] msg_in,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] msg
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] msg_q;
  logic [DATA_W-1:0] dummy;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= ONE;
      else if (init)                        q <= ONE;
      else if (wr_en && (wr_sel == 1'(g)))  q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    msg_q <= '0;
    else if (init) msg_q <= msg_in;
  end

  assign acc   = g_bank[0].q;
  assign dummy = g_bank[1].q;
  assign msg   = msg_q;

  // R2: the accumulator starts every run at one
  p_init_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> acc == ONE);
  // R9: the message is only reloaded on an accepted start
  p_msg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> $stable(msg));
  // R5: the dummy changes only through a dummy-destined write
  p_dummy_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) && !init |=> $stable(dummy));
  // R5: a dummy-destined write leaves the accumulator alone
  p_acc_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && !init |=> $stable(acc));

endmodule

// File: rtl/mx_seq_fsm.sv
module mx_seq_fsm
  import modexp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   mul_done,
  input  logic   cur_bit,
  input  logic   last_bit,
  output logic   load,
  output logic   shift,
  output logic   wr_en,
  output logic   wr_sel,
  output logic   cmd_go,
  output mm_op_e cmd_op,
  output logic   cmd_dst,
  output logic   fin,
  output logic   busy
);
  seq_state_e state_q, state_d;
  mm_op_e     last_op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start)    state_d = S_SQR_GO;
      S_SQR_GO:                 state_d = S_SQR_WAIT;
      S_SQR_WAIT: if (mul_done) state_d = S_MUL_GO;
      S_MUL_GO:                 state_d = S_MUL_WAIT;
      S_MUL_WAIT: if (mul_done) state_d = last_bit ? S_FIN : S_SQR_GO;
      S_FIN:                    state_d = S_IDLE;
      default:                  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign load    = (state_q == S_IDLE) && start;
  assign cmd_go  = (state_q == S_SQR_GO) || (state_q == S_MUL_GO);
  assign cmd_op  = (state_q == S_MUL_GO) ? OP_MUL : OP_SQR;
  assign cmd_dst = (state_q == S_MUL_GO) ? mul_target(cur_bit) : 1'b0;
  assign wr_en   = mul_done && ((state_q == S_SQR_WAIT) || (state_q == S_MUL_WAIT));
  assign wr_sel  = (state_q == S_MUL_WAIT) ? mul_target(cur_bit) : 1'b0;
  assign shift   = mul_done && (state_q == S_MUL_WAIT);
  assign fin     = (state_q == S_FIN);
  assign busy    = (state_q != S_IDLE);

  // Checker state: operation of the most recent command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_op_q <= OP_MUL;
    else if (cmd_go) last_op_q <= cmd_op;
  end

  // R7: command strobe lasts one cycle
  p_cmd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);
  // R7: no command while a result is awaited
  p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_SQR_WAIT) || (state_q == S_MUL_WAIT)) && !mul_done |=> !cmd_go);
  // R3: square and multiply alternate
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> cmd_op != last_op_q);
  // R9: start does not disturb a run
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |-> !load);

endmodule

// File: rtl/modexp_seq.sv
module modexp_seq
  import modexp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [DATA_W-1:0] msg_in,
  output logic              busy,
  output logic              result_valid,
  output logic [DATA_W-1:0] result,
  output logic              mul_start,
  output logic              mul_op,
  output logic              mul_dst,
  output logic [DATA_W-1:0] mul_a,
  output logic [DATA_W-1:0] mul_b,
  input  logic              mul_done,
  input  logic [DATA_W-1:0] mul_res
);
  localparam int CMDW = $clog2(cmd_budget(EXP_W) + 1);

  logic              load, shift, wr_en, wr_sel, fin;
  logic              cur_bit, last_bit;
  logic              cmd_go, cmd_dst;
  mm_op_e            cmd_op;
  logic [DATA_W-1:0] acc, msg;
  logic [DATA_W-1:0] res_q;
  logic              valid_q;

  mx_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mul_done(mul_done),
    .cur_bit(cur_bit), .last_bit(last_bit), .load(load), .shift(shift),
    .wr_en(wr_en), .wr_sel(wr_sel), .cmd_go(cmd_go), .cmd_op(cmd_op),
    .cmd_dst(cmd_dst), .fin(fin), .busy(busy)
  );

  mx_bit_scanner #(.EXP_W(EXP_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .exp_in(exp_in), .cur_bit(cur_bit), .last_bit(last_bit)
  );

  mx_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .init(load), .msg_in(msg_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(mul_res),
    .acc(acc), .msg(msg)
  );

  assign mul_start = cmd_go;
  assign mul_op    = cmd_op;
  assign mul_dst   = cmd_dst;
  assign mul_a     = acc;
  assign mul_b     = (cmd_op == OP_MUL) ? msg : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fin;
      if (fin) res_q <= acc;
    end
  end

  assign result       = res_q;
  assign result_valid = valid_q;

  // Checker: commands issued in the current run
  logic [CMDW-1:0] cmd_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_cnt_q <= '0;
    else if (load)   cmd_cnt_q <= '0;
    else if (cmd_go) cmd_cnt_q <= cmd_cnt_q + 1'b1;
  end

  // R6, R11: fixed command count per run
  p_cmd_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> cmd_cnt_q == CMDW'(cmd_budget(EXP_W)));
  // R8: valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R10: busy has dropped when the result is announced
  p_busy_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);
  // R4: a square reads the accumulator on both operands
  p_sqr_operands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start && !mul_op |-> (mul_a == mul_b) && !mul_dst);
  // R1: quiet outputs right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !result_valid && !mul_start);

endmodule

// File: tb/tb_modexp_seq.sv
module tb_modexp_seq;
  localparam int EXP_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [EXP_W-1:0]  exp_in = '0;
  logic [DATA_W-1:0] msg_in = '0;
  logic              busy, result_valid, mul_start, mul_op, mul_dst;
  logic [DATA_W-1:0] result, mul_a, mul_b;
  logic              mul_done = 1'b0;
  logic [DATA_W-1:0] mul_res = '0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  modexp_seq #(.EXP_W(EXP_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in), .msg_in(msg_in),
    .busy(busy), .result_valid(result_valid), .result(result),
    .mul_start(mul_start), .mul_op(mul_op), .mul_dst(mul_dst),
    .mul_a(mul_a), .mul_b(mul_b), .mul_done(mul_done), .mul_res(mul_res)
  );

  // Behavioural modular multiplier
  int unsigned mod_n = 251;
  int          lat = 0;
  int          m_cnt = 0;
  bit          m_busy = 1'b0;
  logic [DATA_W-1:0] m_val = '0;

  always @(posedge clk) begin
    mul_done <= 1'b0;
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= 0;
    end else if (mul_start) begin
      m_val  <= DATA_W'((32'(mul_a) * 32'(mul_b)) % mod_n);
      m_cnt  <= lat;
      m_busy <= 1'b1;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        mul_done <= 1'b1;
        mul_res  <= m_val;
        m_busy   <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // Port monitor: recomputes every command from the job's own operands
  logic [EXP_W-1:0]  cur_exp = '0;
  logic [DATA_W-1:0] cur_msg = '0;
  int unsigned       acc_e = 1;
  int                cmd_idx = 0;
  int                seq_err = 0;
  int                out_err = 0;
  bit                pending = 1'b0;

  always @(negedge clk) begin
    if (rst_n && mul_start) begin
      if (pending) out_err++;
      pending = 1'b1;
      if (cmd_idx < 2 * EXP_W) begin
        automatic bit kb = cur_exp[EXP_W - 1 - cmd_idx / 2];
        if (cmd_idx % 2 == 0) begin
          if (mul_op !== 1'b0 || mul_dst !== 1'b0 || mul_a != acc_e || mul_b != acc_e) seq_err++;
          acc_e = (acc_e * acc_e) % mod_n;
        end else begin
          if (mul_op !== 1'b1 || mul_dst !== ~kb || mul_a != acc_e || mul_b != cur_msg) seq_err++;
          if (kb) acc_e = (acc_e * cur_msg) % mod_n;
        end
      end
      cmd_idx++;
    end
    if (mul_done) pending = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int unsigned ref_pow(input int unsigned m, input logic [EXP_W-1:0] e,
                                          input int unsigned n);
    int unsigned r = 1 % n;
    int unsigned b = m % n;
    for (int i = 0; i < EXP_W; i++) begin
      if (e[i]) r = (r * b) % n;
      b = (b * b) % n;
    end
    return r;
  endfunction

  task automatic run_exp(input logic [EXP_W-1:0] e, input int unsigned m, input int unsigned n,
                         input int l, input bit poke, input string tag);
    int unsigned want = ref_pow(m, e, n);
    int guard = 0;
    mod_n = n; lat = l; cur_exp = e; cur_msg = DATA_W'(m);
    acc_e = 1; cmd_idx = 0; seq_err = 0; out_err = 0;
    @(negedge clk);
    start = 1'b1; exp_in = e; msg_in = DATA_W'(m);
    @(negedge clk);
    start = 1'b0; exp_in = ~e; msg_in = DATA_W'(m + 1);
    check(busy === 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    while (!result_valid && guard < 5000) begin
      start = (poke && guard == 5);
      if (poke && guard == 5) begin exp_in = ~e; msg_in = DATA_W'((m + 3) % n); end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check(result_valid === 1'b1, "R8", {tag, " result announced"}, result_valid, 1);
    check(result == DATA_W'(want), "R8", {tag, " result value"}, result, want);
    check(busy === 1'b0, "R10", {tag, " busy low at valid"}, busy, 0);
    check(cmd_idx == 2 * EXP_W, "R6", {tag, " command count"}, cmd_idx, 2 * EXP_W);
    check(seq_err == 0, "R3 R4 R5", {tag, " command stream"}, seq_err, 0);
    check(out_err == 0, "R7", {tag, " single outstanding"}, out_err, 0);
    @(negedge clk);
    check(result_valid === 1'b0, "R8", {tag, " valid pulse width"}, result_valid, 0);
    check(result == DATA_W'(want), "R8", {tag, " result held"}, result, want);
  endtask

  task automatic t_reset();
    check(busy === 1'b0, "R1", "busy in reset", busy, 0);
    check(result_valid === 1'b0, "R1", "valid in reset", result_valid, 0);
    check(mul_start === 1'b0, "R1", "mul_start in reset", mul_start, 0);
  endtask

  task automatic t_first_cmd();
    // R2: first command squares the value one
    mod_n = 251; lat = 0; cur_exp = 8'h5A; cur_msg = 16'd9;
    acc_e = 1; cmd_idx = 0; seq_err = 0; out_err = 0;
    @(negedge clk); start = 1'b1; exp_in = 8'h5A; msg_in = 16'd9;
    @(negedge clk); start = 1'b0;
    check(mul_start === 1'b1, "R2", "first strobe", mul_start, 1);
    check(mul_a == 16'd1 && mul_b == 16'd1, "R2", "first operands", mul_a, 1);
    while (!result_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_held();
    logic [DATA_W-1:0] keep = result;
    repeat (6) @(negedge clk);
    check(result == keep, "R8", "result held while idle", result, keep);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_cmd();
    run_exp(8'h00, 77, 251, 0, 1'b0, "R11 zero exponent");
    run_exp(8'hFF, 7, 251, 0, 1'b0, "all ones");
    run_exp(8'h80, 13, 199, 2, 1'b0, "top bit only");
    run_exp(8'h01, 123, 241, 3, 1'b0, "low bit only");
    run_exp(8'hA5, 50, 97, 1, 1'b0, "alternating");
    run_exp(8'h3C, 21, 233, 4, 1'b1, "R9 start while busy");
    t_held();
    for (int k = 0; k < 10; k++) begin
      automatic int unsigned n = 3 + ($urandom % 253);
      automatic int unsigned m = $urandom % n;
      automatic logic [EXP_W-1:0] e = EXP_W'($urandom);
      run_exp(e, m, n, k % 4, 1'b0, "random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule